// File: doc/BRIEF.md
# Protection Information Tuple Checker

This block checks the protection tuple that accompanies each logical block read back from storage. A command opens with a one-cycle `cmd_start` pulse that carries the command parameters. These are the start LBA, the initial reference tag, the expected application tag and its mask, three check-enable bits, the protection type and the tuple format. The blocks then stream in. For each block, data beats arrive on `dat_valid`/`dat`, and the block's tuple arrives on `blk_valid`. The tuple consists of a guard computed elsewhere, the stored guard, the stored application tag and the stored reference tag. A `blk_last` flag marks the final block.

One cycle after the final block, or after the first block that fails, the block pulses `done` and presents a status. Guard arithmetic, memory access and host transfer happen outside it. The block handles tag escape values that turn checking off for a block. It runs the checks in a fixed priority order. It applies a start-LBA consistency check before any block. It also forgives a guard mismatch on an all-zero first block at LBA 0, and pulses `fill_ones` so that the surrounding logic rewrites that tuple to all ones.

Top module: `pi_tuple_checker`

## Requirements
- R1: On `cmd_start`, if `pi_type`=1, `chk_en[2]`=1, and the start LBA and initial reference tag differ when both are masked to 32 bits (`wide_fmt`=0) or 48 bits (`wide_fmt`=1), then in the next cycle `done`=1, `status`=4 and `dnr`=1, and no block is checked. In every other case `dnr` stays 0.
- R2: For `pi_type` 1 or 2, a block whose stored application tag is 16'hFFFF passes regardless of guard and tags.
- R3: For `pi_type` 3, a block passes unchecked only when its application tag is 16'hFFFF and its stored reference tag is all ones within the format width. An all-ones application tag alone does not skip the checks.
- R4: Status codes are 0 success, 1 guard error, 2 application-tag error, 3 reference-tag error and 4 invalid protection info. The enabled checks run in the order guard, application tag, reference tag. The first failing block ends the command, and `done` pulses one cycle after that block or after the block flagged `blk_last`.
- R5: The application-tag check compares (stored AND mask) against (expected AND mask). Bits outside the mask never cause an error.
- R6: The expected reference tag starts at the initial reference tag. It increases by one after every block for types 1 and 2 and stays fixed for type 3.
- R7: A guard error is forgiven when it occurs on the first block of a command, the start LBA is 0, and every data beat of that block was zero. In that case `fill_ones` pulses one cycle after the block and checking continues with the next block. A forgiven block does not undergo the application-tag or reference-tag checks.
- R8: With `wide_fmt`=1 the full 64-bit guard and the 48-bit reference tag are compared. The reference tag bytes are taken as most significant first, `tup_ref[47:40]` being the first stored byte. With `wide_fmt`=0 only `calc_guard[15:0]`/`tup_guard[15:0]` and `tup_ref[31:0]` are compared.
- R9: `chk_en[0]`, `chk_en[1]` and `chk_en[2]` enable the guard, application-tag and reference-tag checks respectively. A disabled check never reports an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a command and latches its parameters |
| start_lba | input | 48 | First LBA of the command |
| ref_init | input | 48 | Initial expected reference tag |
| exp_app | input | 16 | Expected application tag |
| app_mask | input | 16 | Application-tag compare mask |
| chk_en | input | 3 | Check enables: [0] guard, [1] app tag, [2] ref tag |
| pi_type | input | 2 | Protection type 1, 2 or 3 |
| wide_fmt | input | 1 | 0: 16-bit guard/32-bit ref, 1: 64-bit guard/48-bit ref |
| dat_valid | input | 1 | Data beat valid for the current block |
| dat | input | DW | Data beat |
| blk_valid | input | 1 | Tuple of the current block is present |
| blk_last | input | 1 | Current block is the last of the command |
| calc_guard | input | 64 | Guard computed over the block |
| tup_guard | input | 64 | Stored guard |
| tup_app | input | 16 | Stored application tag |
| tup_ref | input | 48 | Stored reference tag, first byte in bits [47:40] |
| done | output | 1 | One-cycle status pulse |
| status | output | 3 | Command status, valid with `done` |
| dnr | output | 1 | Do-not-retry, set with invalid protection info |
| fill_ones | output | 1 | Tuple of the forgiven first block is to be set to all ones |

## Verification
The bench feeds command streams that differ in a single respect, so that each result can come from only one rule. Blocks with several corrupted fields at once separate the three check priorities, and mask-only differences in the application tag show that masked-off bits are ignored. Tag escape values are applied under each protection type, which separates the type 1/2 rule from the stricter type 3 rule. Multi-block commands with sequential and with constant reference tags separate the two increment behaviours. The zero-block forgiveness is tried with zero and non-zero data, with a non-zero start LBA and on a later block, and only the first case may pass. Both tuple formats are run with differences confined to the upper guard and reference bits, and only the wide format may report them.

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic [47:0]   start_lba,
  input  logic [47:0]   ref_init,
  input  logic [15:0]   exp_app,
  input  logic [15:0]   app_mask,
  input  logic [2:0]    chk_en,
  input  logic [1:0]    pi_type,
  input  logic          wide_fmt,
  input  logic          dat_valid,
  input  logic [DW-1:0] dat,
  input  logic          blk_valid,
  input  logic          blk_last,
  input  logic [63:0]   calc_guard,
  input  logic [63:0]   tup_guard,
  input  logic [15:0]   tup_app,
  input  logic [47:0]   tup_ref,
  output logic          done,
  output logic [2:0]    status,
  output logic          dnr,
  output logic          fill_ones
);
  localparam logic [2:0] ST_OK = 3'd0, ST_GUARD = 3'd1, ST_APP = 3'd2,
                         ST_REF = 3'd3, ST_INVAL = 3'd4;
  localparam logic [47:0] M48 = 48'hFFFF_FFFF_FFFF, M32 = 48'h0000_FFFF_FFFF;

  logic        busy_q, first_q, nz_q, wide_q, lba_zero_q;
  logic [1:0]  type_q;
  logic [2:0]  en_q;
  logic [15:0] app_q, mask_q;
  logic [47:0] exp_ref_q;

  wire [47:0] in_w    = wide_fmt ? M48 : M32;
  wire [47:0] ref_w   = wide_q ? M48 : M32;
  wire        pre_bad = (pi_type == 2'd1) && chk_en[2] &&
                        ((start_lba & in_w) != (ref_init & in_w));

  wire [47:0] sref    = tup_ref & ref_w;
  wire        nz_now  = nz_q | (dat_valid && (|dat));
  wire        escape  = (tup_app == 16'hFFFF) &&
                        ((type_q == 2'd1) || (type_q == 2'd2) ||
                         ((type_q == 2'd3) && (sref == ref_w)));
  wire        g_bad   = en_q[0] && (wide_q ? (calc_guard != tup_guard)
                                           : (calc_guard[15:0] != tup_guard[15:0]));
  wire        a_bad   = en_q[1] && ((tup_app & mask_q) != (app_q & mask_q));
  wire        r_bad   = en_q[2] && (sref != exp_ref_q);
  wire        forgive = g_bad && first_q && lba_zero_q && !nz_now;

  logic [2:0] code;
  always_comb begin
    if (escape)     code = ST_OK;
    else if (g_bad) code = forgive ? ST_OK : ST_GUARD;
    else if (a_bad) code = ST_APP;
    else if (r_bad) code = ST_REF;
    else            code = ST_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; first_q <= 1'b0; nz_q <= 1'b0; wide_q <= 1'b0;
      lba_zero_q <= 1'b0; type_q <= 2'd0; en_q <= 3'd0; app_q <= 16'd0;
      mask_q <= 16'd0; exp_ref_q <= 48'd0;
      done <= 1'b0; status <= ST_OK; dnr <= 1'b0; fill_ones <= 1'b0;
    end else begin
      done <= 1'b0; dnr <= 1'b0; fill_ones <= 1'b0;
      if (cmd_start) begin
        wide_q <= wide_fmt; type_q <= pi_type; en_q <= chk_en;
        app_q <= exp_app; mask_q <= app_mask;
        exp_ref_q <= ref_init & in_w;
        lba_zero_q <= (start_lba == 48'd0);
        first_q <= 1'b1; nz_q <= 1'b0;
        busy_q <= !pre_bad;
        if (pre_bad) begin
          done <= 1'b1; status <= ST_INVAL; dnr <= 1'b1;
        end
      end else if (busy_q && blk_valid) begin
        first_q <= 1'b0; nz_q <= 1'b0;
        if (type_q != 2'd3) exp_ref_q <= (exp_ref_q + 48'd1) & ref_w;
        fill_ones <= forgive && !escape;
        if (code != ST_OK || blk_last) begin
          busy_q <= 1'b0; done <= 1'b1; status <= code;
        end
      end else if (busy_q && dat_valid) begin
        nz_q <= nz_now;
      end
    end
  end

  AST_DNR_WITH_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    dnr |-> done && status == ST_INVAL); // R1
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cmd_start) || $past(busy_q && blk_valid)); // R4
  AST_DONE_ENDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_q); // R4
  AST_T3_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && type_q == 2'd3 && !cmd_start |=> $stable(exp_ref_q)); // R6
  AST_FILL_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ones |-> $past(first_q && lba_zero_q && blk_valid)); // R7
endmodule

// File: tb/test_pi_tuple_checker.sv
module test_pi_tuple_checker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, wide_fmt = 0, dat_valid = 0, blk_valid = 0, blk_last = 0;
  logic [47:0] start_lba = 0, ref_init = 0, tup_ref = 0;
  logic [15:0] exp_app = 0, app_mask = 0, tup_app = 0;
  logic [2:0] chk_en = 0;
  logic [1:0] pi_type = 0;
  logic [31:0] dat = 0;
  logic [63:0] calc_guard = 0, tup_guard = 0;
  logic done, dnr, fill_ones;
  logic [2:0] status;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pi_tuple_checker #(.DW(32)) i_pi_tuple_checker (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic [47:0] lba, input logic [47:0] rf, input logic [15:0] ap,
                       input logic [15:0] mk, input logic [2:0] en, input logic [1:0] ty,
                       input logic wd);
    @(negedge clk);
    cmd_start = 1; start_lba = lba; ref_init = rf; exp_app = ap; app_mask = mk;
    chk_en = en; pi_type = ty; wide_fmt = wd;
    @(negedge clk);
    cmd_start = 0;
  endtask

  // one block: one data beat and the tuple in the same cycle; outputs seen at the next negedge
  task automatic blk(input logic [31:0] d, input logic [63:0] cg, input logic [63:0] sg,
                     input logic [15:0] ap, input logic [47:0] rf, input logic last);
    dat_valid = 1; dat = d; blk_valid = 1; blk_last = last;
    calc_guard = cg; tup_guard = sg; tup_app = ap; tup_ref = rf;
    @(negedge clk);
    dat_valid = 0; blk_valid = 0; blk_last = 0;
  endtask

  task automatic expect_done(input string req, input logic [2:0] st);
    chk(req, {31'd0, done}, 1);
    chk(req, {29'd0, status}, {29'd0, st});
  endtask

  task automatic t_reset;
    chk("R4 reset done", {31'd0, done}, 0);
    chk("R4 reset status", {29'd0, status}, 0);
    chk("R1 reset dnr", {31'd0, dnr}, 0);
    chk("R7 reset fill", {31'd0, fill_ones}, 0);
  endtask

  task automatic t_precheck;
    start(48'd5, 48'd6, 0, 0, 3'b100, 2'd1, 0);
    expect_done("R1 lba mismatch", 3'd4);
    chk("R1 dnr", {31'd0, dnr}, 1);
    start(48'h1_0000_0005, 48'd5, 0, 0, 3'b100, 2'd1, 0);
    chk("R1 narrow mask no reject", {31'd0, done}, 0);
    blk(1, 7, 7, 0, 48'd5, 1);
    expect_done("R1 narrow pass", 3'd0);
    chk("R1 dnr clear", {31'd0, dnr}, 0);
    start(48'h1_0000_0005, 48'd5, 0, 0, 3'b100, 2'd1, 1);
    expect_done("R1 wide mismatch", 3'd4);
    start(48'd5, 48'd6, 0, 0, 3'b100, 2'd2, 0);
    chk("R1 type2 no precheck", {31'd0, done}, 0);
    blk(1, 7, 7, 0, 48'd6, 1);
    expect_done("R1 type2 pass", 3'd0);
  endtask

  task automatic t_multi;
    start(48'd10, 48'd10, 16'h1234, 16'hFFFF, 3'b111, 2'd1, 0);
    blk(3, 9, 9, 16'h1234, 48'd10, 0);
    chk("R4 no early done", {31'd0, done}, 0);
    blk(3, 9, 9, 16'h1234, 48'd11, 0);
    blk(3, 9, 9, 16'h1234, 48'd12, 1);
    expect_done("R6 type1 increment", 3'd0);
    start(48'd0, 48'd20, 0, 0, 3'b101, 2'd1, 0);
    expect_done("R1 type1 lba!=ref reject", 3'd4);
    start(48'd0, 48'd20, 0, 0, 3'b101, 2'd2, 0);
    blk(3, 9, 9, 0, 48'd20, 0);
    blk(3, 9, 8, 0, 48'd21, 0);
    expect_done("R4 guard fail second block", 3'd1);
  endtask

  task automatic t_priority;
    start(48'd0, 48'd0, 16'h00AA, 16'hFFFF, 3'b111, 2'd2, 0);
    blk(1, 5, 6, 16'h00AB, 48'd9, 1);
    expect_done("R4 guard first", 3'd1);
    start(48'd0, 48'd0, 16'h00AA, 16'hFFFF, 3'b111, 2'd2, 0);
    blk(1, 5, 5, 16'h00AB, 48'd9, 1);
    expect_done("R4 app second", 3'd2);
    start(48'd0, 48'd0, 16'h00AA, 16'hFFFF, 3'b111, 2'd2, 0);
    blk(1, 5, 5, 16'h00AA, 48'd9, 1);
    expect_done("R4 ref third", 3'd3);
    start(48'd0, 48'd0, 16'h00AA, 16'h00F0, 3'b010, 2'd2, 0);
    blk(1, 5, 5, 16'hFFA5, 48'd0, 1);
    expect_done("R5 masked-off bits ignored", 3'd0);
    start(48'd0, 48'd0, 16'h00AA, 16'h00F0, 3'b010, 2'd2, 0);
    blk(1, 5, 5, 16'h00BA, 48'd0, 1);
    expect_done("R5 masked bit differs", 3'd2);
    start(48'd0, 48'd0, 16'h00AA, 16'hFFFF, 3'b000, 2'd2, 0);
    blk(1, 5, 6, 16'h0001, 48'd77, 1);
    expect_done("R9 all checks off", 3'd0);
  endtask

  task automatic t_escape;
    start(48'd0, 48'd0, 0, 16'hFFFF, 3'b111, 2'd1, 0);
    blk(1, 5, 6, 16'hFFFF, 48'd99, 1);
    expect_done("R2 type1 app escape", 3'd0);
    start(48'd0, 48'd0, 0, 16'hFFFF, 3'b111, 2'd3, 0);
    blk(1, 5, 6, 16'hFFFF, 48'h0000_FFFF_FFFE, 1);
    expect_done("R3 type3 app only not escape", 3'd1);
    start(48'd0, 48'd0, 0, 16'hFFFF, 3'b111, 2'd3, 0);
    blk(1, 5, 6, 16'hFFFF, 48'h1234_FFFF_FFFF, 1);
    expect_done("R3 type3 narrow escape", 3'd0);
    start(48'd0, 48'd0, 0, 16'hFFFF, 3'b111, 2'd3, 1);
    blk(1, 5, 6, 16'hFFFF, 48'h0000_FFFF_FFFF, 1);
    expect_done("R3 type3 wide partial ones", 3'd1);
    start(48'd0, 48'd0, 0, 16'hFFFF, 3'b111, 2'd3, 1);
    blk(1, 5, 6, 16'hFFFF, 48'hFFFF_FFFF_FFFF, 1);
    expect_done("R3 type3 wide escape", 3'd0);
  endtask

  task automatic t_type3_ref;
    start(48'd4, 48'd40, 0, 0, 3'b100, 2'd3, 0);
    blk(1, 0, 0, 0, 48'd40, 0);
    blk(1, 0, 0, 0, 48'd40, 1);
    expect_done("R6 type3 constant", 3'd0);
    start(48'd4, 48'd40, 0, 0, 3'b100, 2'd3, 0);
    blk(1, 0, 0, 0, 48'd40, 0);
    blk(1, 0, 0, 0, 48'd41, 1);
    expect_done("R6 type3 no increment", 3'd3);
  endtask

  task automatic t_forgive;
    start(48'd0, 48'd0, 0, 0, 3'b101, 2'd1, 0);
    blk(0, 5, 6, 0, 48'd0, 0);
    chk("R7 fill pulse", {31'd0, fill_ones}, 1);
    chk("R7 no done", {31'd0, done}, 0);
    blk(0, 5, 5, 0, 48'd1, 1);
    expect_done("R7 forgiven continues", 3'd0);
    chk("R7 fill one cycle", {31'd0, fill_ones}, 0);
    start(48'd0, 48'd0, 0, 0, 3'b101, 2'd1, 0);
    blk(32'h10, 5, 6, 0, 48'd0, 1);
    expect_done("R7 nonzero data", 3'd1);
    start(48'd3, 48'd3, 0, 0, 3'b101, 2'd1, 0);
    blk(0, 5, 6, 0, 48'd3, 1);
    expect_done("R7 lba nonzero", 3'd1);
    start(48'd0, 48'd0, 0, 0, 3'b101, 2'd1, 0);
    blk(0, 5, 5, 0, 48'd0, 0);
    blk(0, 5, 6, 0, 48'd1, 1);
    expect_done("R7 second block not forgiven", 3'd1);
    start(48'd0, 48'd0, 0, 0, 3'b101, 2'd1, 0);
    @(negedge clk); dat_valid = 1; dat = 32'h100; @(negedge clk); dat_valid = 0;
    blk(0, 5, 6, 0, 48'd0, 1);
    expect_done("R7 earlier beat nonzero", 3'd1);
  endtask

  task automatic t_wide;
    start(48'd0, 48'd0, 0, 0, 3'b001, 2'd2, 0);
    blk(1, 64'hAAAA_0000_0000_1234, 64'h5555_0000_0000_1234, 0, 0, 1);
    expect_done("R8 narrow guard low bits", 3'd0);
    start(48'd0, 48'd0, 0, 0, 3'b001, 2'd2, 1);
    blk(1, 64'hAAAA_0000_0000_1234, 64'h5555_0000_0000_1234, 0, 0, 1);
    expect_done("R8 wide guard full", 3'd1);
    start(48'h0, 48'h0102_0304_0506, 0, 0, 3'b100, 2'd2, 1);
    blk(1, 0, 0, 0, 48'h0102_0304_0506, 0);
    blk(1, 0, 0, 0, 48'h0102_0304_0507, 1);
    expect_done("R8 wide 48-bit ref", 3'd0);
    start(48'h0, 48'h0102_0304_0506, 0, 0, 3'b100, 2'd2, 1);
    blk(1, 0, 0, 0, 48'h0002_0304_0506, 1);
    expect_done("R8 wide ref top byte", 3'd3);
    start(48'h0, 48'h0000_0304_0506, 0, 0, 3'b100, 2'd2, 0);
    blk(1, 0, 0, 0, 48'hFF00_0304_0506, 1);
    expect_done("R8 narrow ref upper ignored", 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_precheck();
    t_multi();
    t_priority();
    t_escape();
    t_type3_ref();
    t_forgive();
    t_wide();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule